// File: doc/BRIEF.md
# Chip Power State Combiner

This block keeps the low-power mode of the application processor and combines it with the status reported by the network processor. From that pair it derives one chip-level power state. The application side asks for a mode through a request strobe. The network side reports its status continuously. The block drives a clock-gate enable and a power-gate enable, a retention mask for on-chip memory organised in 64KB banks, and a one-cycle wake request.

A wake request is raised when a wake event arrives that the current low-power mode permits and that software has enabled for that mode. Each depth of sleep permits a smaller set of wake sources. Hibernate is granted only while the network side is disabled. A hibernate request made at any other time is refused and leaves a sticky error flag behind.

Top module: `pwr_state_combiner`

## Requirements
- R1: After reset the application mode is active, chip_state is 0, clk_gate_en, pwr_gate_en, wake_req and hib_err are 0, and ret_mask is all ones.
- R2: The block takes a request (req_valid high; req_mode 0 active, 1 sleep, 2 deep sleep, 3 hibernate) only while the application mode is active, and the new mode applies from the next clock edge. A request made while the application mode is sleep, deep sleep or hibernate has no effect.
- R3: A hibernate request is refused when net_state is not 2 (disabled). The application mode then stays active and hib_err becomes 1 at the next edge. hib_err stays at 1 until reset.
- R4: chip_state (0 active, 1 deep sleep, 2 hibernate) is 0 when the application mode is active or sleep. In deep sleep it is 0 when net_state is 0 (active) or 3 (reserved, treated as active), and 1 when net_state is 1 (deep sleep) or 2 (disabled). In hibernate it is 2.
- R5: clk_gate_en is 1 exactly when the application mode is not active. pwr_gate_en is 1 exactly when chip_state is not 0.
- R6: In sleep, every wake source is permitted: bit 0 fast timer, bit 1 RTC, bits 2 to 9 GPIO0 to GPIO7, bit 10 peripheral.
- R7: In deep sleep, only the RTC (bit 1) and the GPIO sources (bits 2 to 9) are permitted.
- R8: In hibernate, only the RTC (bit 1) and GPIO0 to GPIO6 (bits 2 to 8) are permitted.
- R9: A wake event counts only if its bit is set in the enable vector of the current mode (wake_en_sleep, wake_en_lpds or wake_en_hib) and the mode permits the source. A counted wake returns the application mode to active at the next edge and drives wake_req high for exactly that one cycle.
- R10: ret_mask is all ones in active and sleep, and all zeros in hibernate. In deep sleep it holds the ret_sel value captured when the deep-sleep request was accepted, one bit per 64KB bank, bit 0 for the lowest bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode request strobe from the application side |
| req_mode | input | 2 | Requested application mode |
| net_state | input | 2 | Network processor status |
| ret_sel | input | BANKS (4) | Banks to keep during deep sleep |
| wake_evt | input | WAKE_W (11) | Wake event lines |
| wake_en_sleep | input | WAKE_W (11) | Wake enables used in sleep |
| wake_en_lpds | input | WAKE_W (11) | Wake enables used in deep sleep |
| wake_en_hib | input | WAKE_W (11) | Wake enables used in hibernate |
| chip_state | output | 2 | Resolved chip power state |
| clk_gate_en | output | 1 | Gate the application clocks |
| pwr_gate_en | output | 1 | Power-gate the switchable logic |
| wake_req | output | 1 | One-cycle wake pulse |
| hib_err | output | 1 | Sticky flag for a refused hibernate request |
| ret_mask | output | BANKS (4) | Memory banks kept powered |

## Verification
The assertions assume that the network side stays disabled for as long as the application side is in hibernate. They also assume that wake events are applied as single-cycle pulses, so a wake is never still present during the cycle in which the block is already back in active.

The stimulus follows both assumptions. Each scenario starts from reset with a fixed net_state. It then issues one request, applies one single-cycle wake event and clears it before the next edge. It changes net_state only during deep sleep, where the resolution table allows for the change.

// File: rtl/pwr_comb_pkg.sv
package pwr_comb_pkg;

  typedef enum logic [1:0] {
    APP_ACT   = 2'd0,
    APP_SLEEP = 2'd1,
    APP_LPDS  = 2'd2,
    APP_HIB   = 2'd3
  } app_mode_t;

  typedef enum logic [1:0] {
    NET_ACT  = 2'd0,
    NET_LPDS = 2'd1,
    NET_OFF  = 2'd2,
    NET_RSVD = 2'd3
  } net_mode_t;

  typedef enum logic [1:0] {
    CHIP_ACT  = 2'd0,
    CHIP_LPDS = 2'd1,
    CHIP_HIB  = 2'd2
  } chip_mode_t;

  // Two-subsystem resolution table
  function automatic chip_mode_t resolve_chip(app_mode_t app, net_mode_t net);
    chip_mode_t r;
    case (app)
      APP_ACT, APP_SLEEP: r = CHIP_ACT;
      APP_LPDS: r = (net == NET_LPDS || net == NET_OFF) ? CHIP_LPDS : CHIP_ACT;
      default: r = CHIP_HIB;
    endcase
    return r;
  endfunction

  // A hibernate entry needs a silent network side
  function automatic logic hib_allowed(net_mode_t net);
    return net == NET_OFF;
  endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
  import pwr_comb_pkg::*;
#(
  parameter int N_GPIO     = 8,
  parameter int N_HIB_GPIO = 7,
  localparam int WAKE_W    = N_GPIO + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  app_mode_t         app_mode,
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic [WAKE_W-1:0] en_sleep,
  input  logic [WAKE_W-1:0] en_lpds,
  input  logic [WAKE_W-1:0] en_hib,
  output logic [WAKE_W-1:0] wake_sel,
  output logic              wake_hit
);

  localparam int IDX_TIMER = 0;
  localparam int IDX_RTC   = 1;
  localparam int IDX_GPIO0 = 2;
  localparam int IDX_PERIPH = IDX_GPIO0 + N_GPIO;

  // Sources a mode may ever be woken by
  function automatic logic [WAKE_W-1:0] allow_mask(app_mode_t m);
    logic [WAKE_W-1:0] a;
    a = '0;
    case (m)
      APP_SLEEP: a = '1;
      APP_LPDS: begin
        a[IDX_RTC] = 1'b1;
        for (int i = 0; i < N_GPIO; i++) a[IDX_GPIO0 + i] = 1'b1;
      end
      APP_HIB: begin
        a[IDX_RTC] = 1'b1;
        for (int i = 0; i < N_HIB_GPIO; i++) a[IDX_GPIO0 + i] = 1'b1;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  logic [WAKE_W-1:0] en_cur;
  logic [WAKE_W-1:0] allow_cur;

  always_comb begin
    case (app_mode)
      APP_SLEEP: en_cur = en_sleep;
      APP_LPDS:  en_cur = en_lpds;
      APP_HIB:   en_cur = en_hib;
      default:   en_cur = '0;
    endcase
  end

  assign allow_cur = allow_mask(app_mode);
  assign wake_sel  = wake_evt & en_cur & allow_cur;
  assign wake_hit  = |wake_sel;

  // R9: no wake is counted in active mode
  p_no_hit_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |-> app_mode != APP_ACT);

  // R6: the fast timer and the peripheral can wake only from sleep
  p_timer_sleep_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sel[IDX_TIMER] || wake_sel[IDX_PERIPH]) |-> app_mode == APP_SLEEP);

  // R8: in hibernate a counted wake is always in the permitted band
  p_hib_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (app_mode == APP_HIB && wake_hit) |-> (wake_sel[IDX_PERIPH] == 1'b0 && wake_sel[IDX_TIMER] == 1'b0));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_comb_pkg::*;
#(
  parameter int BANKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  app_mode_t        req_mode,
  input  net_mode_t        net_state,
  input  logic [BANKS-1:0] ret_sel,
  input  logic             wake_hit,
  output app_mode_t        app_mode,
  output logic [BANKS-1:0] ret_hold,
  output logic             hib_err,
  output logic             wake_req,
  output logic             req_take,
  output logic             hib_refuse
);

  logic in_active;
  logic is_hib_req;
  logic wake_take;

  assign in_active  = (app_mode == APP_ACT);
  assign is_hib_req = (req_mode == APP_HIB);
  assign hib_refuse = req_valid && in_active && is_hib_req && !hib_allowed(net_state);
  assign req_take   = req_valid && in_active && !hib_refuse;
  assign wake_take  = !in_active && wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_mode <= APP_ACT;
      ret_hold <= '1;
      hib_err  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      wake_req <= wake_take;
      if (wake_take) begin
        app_mode <= APP_ACT;
      end else if (req_take) begin
        app_mode <= req_mode;
        if (req_mode == APP_LPDS) ret_hold <= ret_sel;
      end
      if (hib_refuse) hib_err <= 1'b1;
    end
  end

  // R3: the error flag never clears outside reset
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hib_err |=> hib_err);

  // R3: a refused request leaves the mode active
  p_refuse_stay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hib_refuse |=> app_mode == APP_ACT && hib_err);

  // R3: hibernate is entered only with the network side off
  p_hib_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && is_hib_req) |-> net_state == NET_OFF);

  // R2: without a wake, a low-power mode does not move
  p_lowpower_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_active && !wake_hit) |=> $stable(app_mode));

  // R9: the wake pulse lands with the return to active and lasts one cycle
  p_wake_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> app_mode == APP_ACT);
  p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

endmodule

// File: rtl/pwr_chip_resolve.sv
module pwr_chip_resolve
  import pwr_comb_pkg::*;
#(
  parameter int BANKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  app_mode_t        app_mode,
  input  net_mode_t        net_state,
  input  logic [BANKS-1:0] ret_hold,
  output chip_mode_t       chip_state,
  output logic             clk_gate_en,
  output logic             pwr_gate_en,
  output logic [BANKS-1:0] ret_mask
);

  assign chip_state  = resolve_chip(app_mode, net_state);
  assign clk_gate_en = (app_mode != APP_ACT);
  assign pwr_gate_en = (chip_state != CHIP_ACT);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_comb begin
      case (app_mode)
        APP_LPDS: ret_mask[b] = ret_hold[b];
        APP_HIB:  ret_mask[b] = 1'b0;
        default:  ret_mask[b] = 1'b1;
      endcase
    end
  end

  // R5: power gating never happens with clocks running
  p_gate_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_gate_en |-> clk_gate_en);

  // R10: hibernate keeps no memory bank
  p_hib_no_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chip_state == CHIP_HIB |-> ret_mask == '0);

  // R4: hibernate is never seen with network activity
  p_hib_net_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_state == CHIP_HIB |-> net_state == NET_OFF);

endmodule

// File: rtl/pwr_state_combiner.sv
module pwr_state_combiner
  import pwr_comb_pkg::*;
#(
  parameter int MEM_KB     = 256,
  parameter int GRAN_KB    = 64,
  parameter int N_GPIO     = 8,
  parameter int N_HIB_GPIO = 7,
  localparam int BANKS     = MEM_KB / GRAN_KB,
  localparam int WAKE_W    = N_GPIO + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [1:0]        net_state,
  input  logic [BANKS-1:0]  ret_sel,
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic [WAKE_W-1:0] wake_en_sleep,
  input  logic [WAKE_W-1:0] wake_en_lpds,
  input  logic [WAKE_W-1:0] wake_en_hib,
  output logic [1:0]        chip_state,
  output logic              clk_gate_en,
  output logic              pwr_gate_en,
  output logic              wake_req,
  output logic              hib_err,
  output logic [BANKS-1:0]  ret_mask
);

  app_mode_t         app_mode;
  net_mode_t         net_m;
  app_mode_t         req_m;
  chip_mode_t        chip_m;
  logic [BANKS-1:0]  ret_hold;
  logic [WAKE_W-1:0] wake_sel;
  logic              wake_hit;
  logic              req_take;
  logic              hib_refuse;

  assign net_m      = net_mode_t'(net_state);
  assign req_m      = app_mode_t'(req_mode);
  assign chip_state = chip_m;

  pwr_wake_qual #(.N_GPIO(N_GPIO), .N_HIB_GPIO(N_HIB_GPIO)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .app_mode (app_mode),
    .wake_evt (wake_evt),
    .en_sleep (wake_en_sleep),
    .en_lpds  (wake_en_lpds),
    .en_hib   (wake_en_hib),
    .wake_sel (wake_sel),
    .wake_hit (wake_hit)
  );

  pwr_mode_ctrl #(.BANKS(BANKS)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_m),
    .net_state  (net_m),
    .ret_sel    (ret_sel),
    .wake_hit   (wake_hit),
    .app_mode   (app_mode),
    .ret_hold   (ret_hold),
    .hib_err    (hib_err),
    .wake_req   (wake_req),
    .req_take   (req_take),
    .hib_refuse (hib_refuse)
  );

  pwr_chip_resolve #(.BANKS(BANKS)) u_resolve (
    .clk         (clk),
    .rst_n       (rst_n),
    .app_mode    (app_mode),
    .net_state   (net_m),
    .ret_hold    (ret_hold),
    .chip_state  (chip_m),
    .clk_gate_en (clk_gate_en),
    .pwr_gate_en (pwr_gate_en),
    .ret_mask    (ret_mask)
  );

  // R2: a taken request and a wake never coincide
  p_req_wake_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_take && wake_hit));

  // R9: a counted wake event comes out as a pulse on the next cycle
  p_hit_to_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && app_mode != APP_ACT) |=> wake_req);

  // R1: wake selection is empty whenever the mode is active
  p_sel_empty_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode == APP_ACT |-> wake_sel == '0);

endmodule

// File: tb/pwr_state_combiner_tb.sv
module pwr_state_combiner_tb;

  localparam int PERIOD = 10;
  localparam int BANKS  = 4;
  localparam int WAKE_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_mode = 2'd0;
  logic [1:0]        net_state = 2'd2;
  logic [BANKS-1:0]  ret_sel = '0;
  logic [WAKE_W-1:0] wake_evt = '0;
  logic [WAKE_W-1:0] wake_en_sleep = '1;
  logic [WAKE_W-1:0] wake_en_lpds = '1;
  logic [WAKE_W-1:0] wake_en_hib = '1;
  logic [1:0]        chip_state;
  logic              clk_gate_en;
  logic              pwr_gate_en;
  logic              wake_req;
  logic              hib_err;
  logic [BANKS-1:0]  ret_mask;

  int n_checks = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  pwr_state_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .net_state(net_state), .ret_sel(ret_sel), .wake_evt(wake_evt),
    .wake_en_sleep(wake_en_sleep), .wake_en_lpds(wake_en_lpds),
    .wake_en_hib(wake_en_hib), .chip_state(chip_state),
    .clk_gate_en(clk_gate_en), .pwr_gate_en(pwr_gate_en),
    .wake_req(wake_req), .hib_err(hib_err), .ret_mask(ret_mask)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_chip(int app, int net);
    if (app <= 1) return 0;
    if (app == 3) return 2;
    return (net == 1 || net == 2) ? 1 : 0;
  endfunction

  function automatic bit permitted(int app, int src);
    if (app == 1) return 1'b1;
    if (app == 2) return src >= 1 && src <= 9;
    if (app == 3) return src >= 1 && src <= 8;
    return 1'b0;
  endfunction

  function automatic int exp_ret(int app, int sel);
    if (app == 2) return sel;
    if (app == 3) return 0;
    return (1 << BANKS) - 1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    wake_evt = '0;
    wake_en_sleep = '1;
    wake_en_lpds = '1;
    wake_en_hib = '1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic request(input int m);
    req_valid = 1'b1;
    req_mode = 2'(m);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_mode(input int app, input int net, input int sel, input int err);
    chk("R4 chip_state", chip_state, exp_chip(app, net));
    chk("R5 clk_gate_en", clk_gate_en, app != 0);
    chk("R5 pwr_gate_en", pwr_gate_en, exp_chip(app, net) != 0);
    chk("R10 ret_mask", ret_mask, exp_ret(app, sel));
    chk("R3 hib_err", hib_err, err);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 chip_state", chip_state, 0);
    chk("R1 clk_gate_en", clk_gate_en, 0);
    chk("R1 pwr_gate_en", pwr_gate_en, 0);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 hib_err", hib_err, 0);
    chk("R1 ret_mask", ret_mask, 15);

    // Sweep: network status x low-power mode x wake source x enable
    for (int net = 0; net < 3; net++) begin
      for (int m = 1; m < 4; m++) begin
        for (int src = 0; src < WAKE_W; src++) begin
          for (int e = 0; e < 2; e++) begin
            bit refused;
            bit woke;
            int app;
            int sel;
            do_reset();
            net_state = 2'(net);
            sel = (src * 3 + m + e) % 16;
            ret_sel = 4'(sel);
            request(m);
            refused = (m == 3) && (net != 2);
            app = refused ? 0 : m;
            check_mode(app, net, sel, refused);
            if (!refused) begin
              if (e == 0) begin
                if (m == 1) wake_en_sleep = ~(11'(1) << src);
                if (m == 2) wake_en_lpds = ~(11'(1) << src);
                if (m == 3) wake_en_hib = ~(11'(1) << src);
              end
              wake_evt = 11'(1) << src;
              @(negedge clk);
              wake_evt = '0;
              woke = (e == 1) && permitted(m, src);
              if (e == 0) chk("R9 disabled source wake_req", wake_req, 0);
              else if (m == 1) chk("R6 sleep wake_req", wake_req, woke);
              else if (m == 2) chk("R7 lpds wake_req", wake_req, woke);
              else chk("R8 hib wake_req", wake_req, woke);
              check_mode(woke ? 0 : m, net, sel, 0);
              @(negedge clk);
              chk("R9 wake_req pulse end", wake_req, 0);
            end
          end
        end
      end
    end

    // R2: requests while asleep are ignored
    do_reset();
    net_state = 2'd2;
    request(1);
    request(3);
    check_mode(1, 2, 0, 0);
    request(2);
    check_mode(1, 2, 0, 0);

    // R4: network status changes during deep sleep
    do_reset();
    net_state = 2'd1;
    ret_sel = 4'b0101;
    request(2);
    check_mode(2, 1, 5, 0);
    net_state = 2'd0;
    #1;
    check_mode(2, 0, 5, 0);
    net_state = 2'd3;
    #1;
    check_mode(2, 3, 5, 0);
    net_state = 2'd2;
    #1;
    check_mode(2, 2, 5, 0);

    // R3: error stays set across later accepted requests
    do_reset();
    net_state = 2'd0;
    request(3);
    check_mode(0, 0, 0, 1);
    request(1);
    check_mode(1, 0, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule